// File: doc/BRIEF.md
# Windowed Survivor Traceback

This block is the survivor-memory stage of a sliding-window Viterbi decoder. Each trellis step it takes one decision vector, carrying one bit per state, together with the index of the state with the best path metric. It stores the vectors in a circular memory. Once it holds a full window plus an acquisition span, it traces back from the best state and produces the decoded bits. Metric computation and add-compare-select are done by the stage in front of it.

A block starts with one configuration word that sets the window length and the acquisition length. Decision vectors are then streamed in until the step flagged as last. Traceback walks newest-to-oldest. Bits found while crossing the acquisition span only serve to settle onto the right path, so they are dropped. The window's bits are written into a reorder buffer at descending addresses and then read out in ascending order, one bit per cycle, with a last flag on the final bit of the block. When the block ends, every remaining window is traced from the best state of the final step, and the acquisition span shrinks to whatever lies beyond the window.

Top module: `windowed_traceback`

## Requirements
- R1: `cfgReady` is high only while the block is idle. In that state `inReady` and `outValid` are low. The block returns to idle in the cycle after the bit flagged last is taken.
- R2: The configuration word carries the window length in bits 31:16 and the acquisition length in bits 15:0, both unsigned. A window of 0 is used as 1, and either value above `MAX_WIN` is used as `MAX_WIN`.
- R3: The state index holds the most recent input bit in its LSB. The decision bit at state s of a step is the MSB of the predecessor, so the predecessor is {d, s>>1}. The decoded bit for a step is the LSB of the traced state. For error-free decision streams the output equals the encoder input, in its original order.
- R4: A block of N steps produces exactly N output bits; bits decoded in the acquisition span are never output.
- R5: `outLast` is high only together with `outValid`, and only on the N-th bit of the block.
- R6: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` keep their values, and no bit is lost.
- R7: With input presented every cycle and N >= W+A, the first `outValid` comes exactly 2*(W+A) cycles after the cycle in which the first decision vector is accepted.
- R8: Blocks whose length is not a multiple of the window, including blocks shorter than W+A and single-step blocks, are decoded completely from the best state of the final step.
- R9: `inReady` is low during traceback and output, so `inReady` and `outValid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgValid | input | 1 | Configuration word valid |
| cfgData | input | 32 | Window length [31:16], acquisition length [15:0] |
| cfgReady | output | 1 | Block idle and accepting configuration |
| inValid | input | 1 | Decision vector valid |
| inDec | input | 2**(CONSTR_LEN-1) | One survivor decision bit per state |
| inBest | input | CONSTR_LEN-1 | Index of the best state after this step |
| inLast | input | 1 | Final step of the block |
| inReady | output | 1 | Decision vector accepted this cycle if valid |
| outValid | output | 1 | Decoded bit valid |
| outData | output | 1 | Decoded bit |
| outLast | output | 1 | Final decoded bit of the block |
| outReady | input | 1 | Downstream accepts the decoded bit |

## Verification
The checker assumes that the upstream side never offers a decision vector before configuration. It also assumes that the configured lengths are clamped as R2 states, so that W+A never exceeds the circular memory. The stimulus always configures first and then streams error-free decision vectors from a reference add-compare-select model driven by a rate-1/2 encoder, so the best-state index is always the true encoder state. Downstream readiness is either held high or toggled in a fixed pattern. Input is changed only on falling edges, so the hold property sees settled values.

// File: rtl/wtb_pkg.sv
package wtb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_TRACE,
    ST_EMIT
  } wtbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeIn;     // store a decision vector
    logic loadTrace;  // seed traceback from newest step
    logic stepTrace;  // one traceback step
    logic keepBit;    // store the traced bit in reorder buffer
  } wtbCtl_t;

endpackage

// File: rtl/wtb_ctrl.sv
module wtb_ctrl
  import wtb_pkg::*;
#(
  parameter int MAX_WIN = 16,
  parameter int CNT_W   = 6,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgValid,
  input  logic [31:0]      cfgData,
  output logic             cfgReady,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic             outValid,
  output logic             outLast,
  input  logic             outReady,
  output wtbCtl_t          ctl,
  output logic [IDX_W-1:0] bitIdx,
  output logic [IDX_W-1:0] emitIdx
);

  wtbState_e        state;
  logic [CNT_W-1:0] winLen, acqLen, fill, wEff, discLeft;
  logic             blockDone;

  logic [CNT_W-1:0] fillInc, traceFill, traceW;
  logic             goTrace, emitEnd, lastWin, reTrace;

  function automatic logic [CNT_W-1:0] satWin(input logic [15:0] v);
    if (v == 16'd0)               return CNT_W'(1);
    else if (v > 16'(MAX_WIN))    return CNT_W'(MAX_WIN);
    else                          return v[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] satAcq(input logic [15:0] v);
    if (v > 16'(MAX_WIN)) return CNT_W'(MAX_WIN);
    else                  return v[CNT_W-1:0];
  endfunction

  always_comb begin
    fillInc   = fill + CNT_W'(1);
    traceFill = (state == ST_FILL) ? fillInc : (fill - wEff);
    traceW    = (traceFill < winLen) ? traceFill : winLen;
    goTrace   = (state == ST_FILL) && inValid &&
                (inLast || (fillInc == winLen + acqLen));
    lastWin   = blockDone && (fill == wEff);
    emitEnd   = (state == ST_EMIT) && outReady &&
                (emitIdx == IDX_W'(wEff - CNT_W'(1)));
    reTrace   = emitEnd && blockDone && !lastWin;

    ctl.takeIn    = (state == ST_FILL) && inValid;
    ctl.loadTrace = goTrace || reTrace;
    ctl.stepTrace = (state == ST_TRACE);
    ctl.keepBit   = (state == ST_TRACE) && (discLeft == '0);

    cfgReady = (state == ST_IDLE);
    inReady  = (state == ST_FILL);
    outValid = (state == ST_EMIT);
    outLast  = (state == ST_EMIT) && lastWin &&
               (emitIdx == IDX_W'(wEff - CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      winLen    <= CNT_W'(1);
      acqLen    <= '0;
      fill      <= '0;
      wEff      <= CNT_W'(1);
      discLeft  <= '0;
      blockDone <= 1'b0;
      bitIdx    <= '0;
      emitIdx   <= '0;
    end else begin
      if (ctl.loadTrace) begin
        wEff     <= traceW;
        discLeft <= traceFill - traceW;
        bitIdx   <= IDX_W'(traceW - CNT_W'(1));
      end
      unique case (state)
        ST_IDLE: if (cfgValid) begin
          winLen    <= satWin(cfgData[31:16]);
          acqLen    <= satAcq(cfgData[15:0]);
          fill      <= '0;
          blockDone <= 1'b0;
          state     <= ST_FILL;
        end
        ST_FILL: if (ctl.takeIn) begin
          fill <= fillInc;
          if (inLast)  blockDone <= 1'b1;
          if (goTrace) state <= ST_TRACE;
        end
        ST_TRACE: begin
          if (discLeft != '0) discLeft <= discLeft - CNT_W'(1);
          else if (bitIdx == '0) begin
            state   <= ST_EMIT;
            emitIdx <= '0;
          end else bitIdx <= bitIdx - IDX_W'(1);
        end
        ST_EMIT: if (outReady) begin
          if (emitEnd) begin
            fill <= fill - wEff;
            if (lastWin)        state <= ST_IDLE;
            else if (blockDone) state <= ST_TRACE;
            else                state <= ST_FILL;
          end else emitIdx <= emitIdx + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wtb_datapath.sv
module wtb_datapath
  import wtb_pkg::*;
#(
  parameter int MAX_WIN = 16,
  parameter int SB      = 4,
  parameter int NSTATE  = 16,
  parameter int DEPTH_W = 5,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wtbCtl_t           ctl,
  input  logic [NSTATE-1:0] inDec,
  input  logic [SB-1:0]     inBest,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [IDX_W-1:0]  emitIdx,
  output logic              outBit
);

  localparam int DEPTH = 1 << DEPTH_W;

  logic [NSTATE-1:0]  decMem [DEPTH];
  logic               reord  [MAX_WIN];
  logic [DEPTH_W-1:0] wrPtr, trPtr;
  logic [SB-1:0]      bestReg, trState;
  logic               predMsb;

  assign predMsb = decMem[trPtr][trState];
  assign outBit  = reord[emitIdx];

  always_ff @(posedge clk) begin
    if (ctl.takeIn) decMem[wrPtr] <= inDec;
    if (ctl.keepBit) reord[bitIdx] <= trState[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      trPtr   <= '0;
      bestReg <= '0;
      trState <= '0;
    end else begin
      if (ctl.takeIn) begin
        wrPtr   <= wrPtr + DEPTH_W'(1);
        bestReg <= inBest;
      end
      if (ctl.loadTrace) begin
        trPtr   <= ctl.takeIn ? wrPtr  : wrPtr - DEPTH_W'(1);
        trState <= ctl.takeIn ? inBest : bestReg;
      end else if (ctl.stepTrace) begin
        trPtr   <= trPtr - DEPTH_W'(1);
        trState <= {predMsb, trState[SB-1:1]};
      end
    end
  end

endmodule

// File: rtl/windowed_traceback.sv
module windowed_traceback
  import wtb_pkg::*;
#(
  parameter int MAX_WIN    = 16,
  parameter int CONSTR_LEN = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgValid,
  input  logic [31:0]                   cfgData,
  output logic                          cfgReady,
  input  logic                          inValid,
  input  logic [(1<<(CONSTR_LEN-1))-1:0] inDec,
  input  logic [CONSTR_LEN-2:0]         inBest,
  input  logic                          inLast,
  output logic                          inReady,
  output logic                          outValid,
  output logic                          outData,
  output logic                          outLast,
  input  logic                          outReady
);

  localparam int SB      = CONSTR_LEN - 1;
  localparam int NSTATE  = 1 << SB;
  localparam int DEPTH_W = $clog2(2 * MAX_WIN);
  localparam int CNT_W   = $clog2(2 * MAX_WIN + 1);
  localparam int IDX_W   = $clog2(MAX_WIN);

  wtbCtl_t          ctl;
  logic [IDX_W-1:0] bitIdx, emitIdx;

  wtb_ctrl #(.MAX_WIN(MAX_WIN), .CNT_W(CNT_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgData(cfgData), .cfgReady(cfgReady),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outLast(outLast), .outReady(outReady),
    .ctl(ctl), .bitIdx(bitIdx), .emitIdx(emitIdx)
  );

  wtb_datapath #(.MAX_WIN(MAX_WIN), .SB(SB), .NSTATE(NSTATE),
                 .DEPTH_W(DEPTH_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .inDec(inDec), .inBest(inBest),
    .bitIdx(bitIdx), .emitIdx(emitIdx),
    .outBit(outData)
  );

endmodule

// File: rtl/wtb_chk.sv
module wtb_chk (
  input logic clk,
  input logic rstN,
  input logic cfgReady,
  input logic inReady,
  input logic outValid,
  input logic outData,
  input logic outLast,
  input logic outReady
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgReady |-> (!inReady && !outValid));

  // R1
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> cfgReady);

  // R5
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

endmodule

bind windowed_traceback wtb_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgReady(cfgReady), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outLast(outLast), .outReady(outReady)
);

// File: tb/windowed_traceback_tb.sv
module windowed_traceback_tb_top;

  localparam int MAXW = 16;
  localparam int KLEN = 5;
  localparam int NS   = 1 << (KLEN - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgValid = 1'b0;
  logic [31:0]   cfgData = '0;
  logic          cfgReady;
  logic          inValid = 1'b0;
  logic [NS-1:0] inDec = '0;
  logic [3:0]    inBest = '0;
  logic          inLast = 1'b0;
  logic          inReady;
  logic          outValid, outData, outLast;
  logic          outReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic          src  [64];
  logic [NS-1:0] decs [64];
  logic [3:0]    bests[64];

  windowed_traceback #(.MAX_WIN(MAXW), .CONSTR_LEN(KLEN)) dut_i (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] codeOf(input logic [4:0] r);
    return {^(r & 5'b11011), ^(r & 5'b10011)};
  endfunction

  // source bits, encoder and reference add-compare-select
  task automatic makeBlock(input int n);
    int pm[NS];
    int npm[NS];
    logic [3:0] s = '0;
    for (int i = 0; i < NS; i++) pm[i] = (i == 0) ? 0 : 100;
    for (int t = 0; t < n; t++) begin
      logic [1:0] rx;
      int bi;
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src[t] = lfsr[0];
      rx     = codeOf({s, src[t]});
      s      = {s[2:0], src[t]};
      bi     = 0;
      for (int ns = 0; ns < NS; ns++) begin
        logic [3:0] p0, p1;
        int m0, m1;
        p0 = 4'(ns >> 1);
        p1 = p0 | 4'b1000;
        m0 = pm[p0] + $countones(codeOf({p0, 1'(ns)}) ^ rx);
        m1 = pm[p1] + $countones(codeOf({p1, 1'(ns)}) ^ rx);
        decs[t][ns] = (m1 < m0);
        npm[ns]     = (m1 < m0) ? m1 : m0;
      end
      for (int ns = 0; ns < NS; ns++) begin
        pm[ns] = npm[ns];
        if (npm[ns] < npm[bi]) bi = ns;
      end
      bests[t] = 4'(bi);
    end
  endtask

  // one block: configure, stream, collect and compare
  task automatic runBlock(input string req, input int w, input int a,
                          input int n, input int mode, input int expLat);
    int firstAcc = -1;
    int firstVal = -1;
    int got = 0;
    int lastSeen = 0;
    bit overlap = 0;
    makeBlock(n);
    @(negedge clk);
    cfgValid = 1'b1;
    cfgData  = {w[15:0], a[15:0]};
    while (!cfgReady) @(negedge clk);
    @(negedge clk);
    cfgValid = 1'b0;
    fork
      begin
        int idx = 0;
        while (idx < n) begin
          inValid = 1'b1;
          inDec   = decs[idx];
          inBest  = bests[idx];
          inLast  = (idx == n - 1);
          if (inReady) begin
            if (idx == 0) firstAcc = cyc;
            idx++;
          end
          @(negedge clk);
        end
        inValid = 1'b0;
        inLast  = 1'b0;
      end
      begin
        bit done = 0;
        bit held = 0;
        logic hData = 1'b0;
        int guard = 0;
        while (!done && guard < 3000) begin
          outReady = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
          if (inReady && outValid) overlap = 1;
          if (held)  // R6
            check(outValid && (outData == hData), "R6", "held bit",
                  int'(outData), int'(hData));
          held = outValid && !outReady;
          hData = outData;
          if (outValid && firstVal < 0) firstVal = cyc;
          if (outValid && outReady) begin
            if (got < 64)  // R3 and R8
              check(outData == src[got], req, $sformatf("bit %0d", got),
                    int'(outData), int'(src[got]));
            if (outLast) lastSeen++;
            // R5
            check(outLast == (got == n - 1), "R5", $sformatf("last at bit %0d", got),
                  int'(outLast), int'(got == n - 1));
            got++;
            if (outLast) done = 1;
          end
          guard++;
          @(negedge clk);
        end
        outReady = 1'b0;
      end
    join
    // R4
    check(got == n, "R4", "bit count", got, n);
    check(lastSeen == 1, "R5", "last count", lastSeen, 1);
    // R9
    check(!overlap, "R9", "inReady with outValid", int'(overlap), 0);
    if (expLat >= 0)  // R7
      check(firstVal - firstAcc == expLat, "R7", "first output latency",
            firstVal - firstAcc, expLat);
    // R1
    check(cfgReady && !inReady && !outValid, "R1", "idle after block",
          int'(cfgReady), 1);
  endtask

  task automatic testReset;
    @(negedge clk);
    inValid = 1'b1;
    @(negedge clk);
    // R1
    check(cfgReady == 1'b1, "R1", "cfgReady after reset", int'(cfgReady), 1);
    check(inReady == 1'b0, "R1", "inReady before config", int'(inReady), 0);
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    inValid = 1'b0;
  endtask

  task automatic testBasic;
    runBlock("R3", 8, 8, 32, 0, 32);
  endtask

  task automatic testPartial;
    runBlock("R8", 6, 4, 23, 0, 20);
    runBlock("R8", 8, 8, 5, 0, -1);
    runBlock("R8", 8, 4, 1, 0, -1);
  endtask

  task automatic testStall;
    runBlock("R6", 5, 10, 37, 1, 30);
  endtask

  task automatic testClamp;
    // R2: window above maximum, window zero, acquisition above maximum
    runBlock("R2", 255, 3, 40, 0, 38);
    runBlock("R2", 0, 2, 10, 0, 6);
    runBlock("R2", 4, 256, 40, 1, 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testPartial();
    testStall();
    testClamp();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule